// File: doc/BRIEF.md
# Quadrature Position and Revolution Counter

This block follows a two-phase incremental encoder. Its phase inputs A and B and its index input Z arrive asynchronously and pass through a two-flop synchronizer. The block keeps a 16-bit position count that runs between zero and a programmable maximum. It also keeps a separate 16-bit revolution count. The revolution count moves when the position wraps, and it can also move on an index edge. The counting source is selectable. Quadrature mode decodes every A/B transition (4x decode). Up/down mode treats A and B as separate count-up and count-down event inputs, each with its own selectable edge.

Two compare values watch the counters and raise sticky match flags, which software clears with a one-cycle pulse. Compare 0 always watches the position count. Compare 1 watches either the position count or the revolution count. Configuration is a set of static register-style inputs.

Top module: `qenc_counter`

## Requirements
- R1: While `rst_n` is low and directly after reset, `pos_cnt` and `rev_cnt` are 0, `dir_up` is 1, and `match0`, `match1`, `illegal`, `pos_evt` and `idx_evt` are 0.
- R2: With `cfg_updown`=0, each transition of exactly one of A/B moves the position by one step. The step is up when the new A differs from the old B (A leads B), and down otherwise.
- R3: In quadrature mode, a transition of A and B in the same sample leaves the counters unchanged and sets the sticky `illegal` flag. Writing `flag_clr[2]` clears the flag.
- R4: With `cfg_updown`=1, a selected edge on A counts up and a selected edge on B counts down. If both are selected in the same sample, the counters are unchanged. The edge code is 00 none, 01 rising, 10 falling, 11 both. It applies to `cfg_a_edge`, `cfg_b_edge` and `cfg_z_edge`.
- R5: An up step from a position at or above `pos_max` wraps the position to 0 and increments `rev_cnt`. A down step from 0 sets the position to `pos_max` and decrements `rev_cnt`.
- R6: A selected Z edge with `cfg_z_clear`=1 sets the position to 0. It also increments `rev_cnt` if `dir_up` is 1, and decrements it otherwise. This takes priority over an A/B step in the same sample. With `cfg_z_clear`=0, a Z edge leaves the counters unchanged.
- R7: `match0` is set while `pos_cnt` equals `cmp0` and stays set until `flag_clr[0]`. If the clear and a match occur in the same cycle, the match wins.
- R8: `match1` compares `cmp1` with `rev_cnt` when `cfg_cmp1_rev`=1, and with `pos_cnt` otherwise. It is sticky, and `flag_clr[1]` clears it.
- R9: `dir_up` shows the direction of the most recent step: 1 for up, 0 for down.
- R10: The counters change three clock edges after an input change. In that same cycle, `pos_evt` pulses for one cycle on a step or Z clear, and `idx_evt` pulses on any selected Z edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ain | input | 1 | Phase A / count-up input (asynchronous) |
| bin | input | 1 | Phase B / count-down input (asynchronous) |
| zin | input | 1 | Index input (asynchronous) |
| cfg_updown | input | 1 | 1: up/down event mode, 0: quadrature mode |
| cfg_a_edge | input | 2 | Edge select for A in up/down mode |
| cfg_b_edge | input | 2 | Edge select for B in up/down mode |
| cfg_z_edge | input | 2 | Edge select for Z |
| cfg_z_clear | input | 1 | Selected Z edge clears the position |
| cfg_cmp1_rev | input | 1 | Compare 1 watches the revolution count |
| pos_max | input | 16 | Position wrap maximum |
| cmp0 | input | 16 | Compare value for the position |
| cmp1 | input | 16 | Compare value for position or revolution |
| flag_clr | input | 3 | Clear pulses: [0] match0, [1] match1, [2] illegal |
| pos_cnt | output | 16 | Position count |
| rev_cnt | output | 16 | Revolution count |
| dir_up | output | 1 | Direction of last step |
| match0 | output | 1 | Sticky compare 0 flag |
| match1 | output | 1 | Sticky compare 1 flag |
| illegal | output | 1 | Sticky illegal-transition flag |
| pos_evt | output | 1 | One-cycle pulse on a counter update |
| idx_evt | output | 1 | One-cycle pulse on a selected Z edge |

## Verification
The bench walks the Gray sequence forward and backward across several wraps with a small maximum. A design that mishandles the boundary would show an off-by-one position, a stuck position, or a revolution count that drifts the wrong way.

It sweeps all sixteen A/B edge-code pairs in up/down mode, including simultaneous edges. A wrong edge decoder shows up as a count that is missing or extra.

It also checks the following corner cases:
- a double transition, which a naive decoder would count;
- a Z clear that coincides with a step, where the wrong priority leaves a nonzero position;
- a flag clear issued while the compare still holds, where a clear-wins design drops the flag;
- the exact three-edge latency.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ain,
  input  logic         bin,
  input  logic         zin,
  input  logic         cfg_updown,
  input  logic [1:0]   cfg_a_edge,
  input  logic [1:0]   cfg_b_edge,
  input  logic [1:0]   cfg_z_edge,
  input  logic         cfg_z_clear,
  input  logic         cfg_cmp1_rev,
  input  logic [W-1:0] pos_max,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] pos_cnt,
  output logic [W-1:0] rev_cnt,
  output logic         dir_up,
  output logic         match0,
  output logic         match1,
  output logic         illegal,
  output logic         pos_evt,
  output logic         idx_evt
);

  // [0],[1] synchronizer, [2] previous synchronized sample
  logic [2:0] sa, sb, sz;

  function automatic logic edge_hit(input logic [1:0] code, input logic cur, input logic prv);
    return (code[0] & cur & ~prv) | (code[1] & ~cur & prv);
  endfunction

  logic a_chg, b_chg, q_step, q_up, q_bad;
  logic ea, eb, z_hit, z_clr, step_up, step_dn;
  logic [W-1:0] cmp1_src;

  assign a_chg   = sa[1] ^ sa[2];
  assign b_chg   = sb[1] ^ sb[2];
  assign q_step  = a_chg ^ b_chg;
  assign q_up    = sa[1] ^ sb[2];
  assign q_bad   = a_chg & b_chg & ~cfg_updown;
  assign ea      = edge_hit(cfg_a_edge, sa[1], sa[2]);
  assign eb      = edge_hit(cfg_b_edge, sb[1], sb[2]);
  assign z_hit   = edge_hit(cfg_z_edge, sz[1], sz[2]);
  assign z_clr   = z_hit & cfg_z_clear;
  assign step_up = cfg_updown ? (ea & ~eb) : (q_step & q_up);
  assign step_dn = cfg_updown ? (eb & ~ea) : (q_step & ~q_up);
  assign cmp1_src = cfg_cmp1_rev ? rev_cnt : pos_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
      sz <= '0;
    end else begin
      sa <= {sa[1:0], ain};
      sb <= {sb[1:0], bin};
      sz <= {sz[1:0], zin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_cnt <= '0;
      rev_cnt <= '0;
      dir_up  <= 1'b1;
      pos_evt <= 1'b0;
      idx_evt <= 1'b0;
    end else begin
      pos_evt <= z_clr | step_up | step_dn;
      idx_evt <= z_hit;
      if (z_clr) begin
        pos_cnt <= '0;
        rev_cnt <= dir_up ? rev_cnt + 1'b1 : rev_cnt - 1'b1;
      end else if (step_up) begin
        dir_up <= 1'b1;
        if (pos_cnt >= pos_max) begin
          pos_cnt <= '0;
          rev_cnt <= rev_cnt + 1'b1;
        end else begin
          pos_cnt <= pos_cnt + 1'b1;
        end
      end else if (step_dn) begin
        dir_up <= 1'b0;
        if (pos_cnt == '0) begin
          pos_cnt <= pos_max;
          rev_cnt <= rev_cnt - 1'b1;
        end else begin
          pos_cnt <= pos_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match0  <= 1'b0;
      match1  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      match0  <= (match0 & ~flag_clr[0]) | (pos_cnt == cmp0);
      match1  <= (match1 & ~flag_clr[1]) | (cmp1_src == cmp1);
      illegal <= (illegal & ~flag_clr[2]) | q_bad;
    end
  end

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !z_clr && pos_cnt >= pos_max) |=> (pos_cnt == '0 && rev_cnt == $past(rev_cnt) + 1'b1));

  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !z_clr && pos_cnt == '0) |=> (pos_cnt == $past(pos_max) && rev_cnt == $past(rev_cnt) - 1'b1));

  assert_double_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_bad && !z_clr) |=> ($stable(pos_cnt) && $stable(rev_cnt) && illegal));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !z_clr) |=> ($stable(pos_cnt) && $stable(rev_cnt) && !pos_evt));

  assert_z_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    z_clr |=> (pos_cnt == '0 && pos_evt));

  assert_match0_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match0 && !flag_clr[0]) |=> match0);

  assert_match1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match1 && !flag_clr[1]) |=> match1);

  assert_dir_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !z_clr) |=> !dir_up);

endmodule

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ain = 0, bin = 0, zin = 0;
  logic cfg_updown = 0, cfg_z_clear = 0, cfg_cmp1_rev = 0;
  logic [1:0] cfg_a_edge = 0, cfg_b_edge = 0, cfg_z_edge = 0;
  logic [15:0] pos_max = 16'd5, cmp0 = 16'hFFFF, cmp1 = 16'hFFFF;
  logic [2:0] flag_clr = 0;
  logic [15:0] pos_cnt, rev_cnt;
  logic dir_up, match0, match1, illegal, pos_evt, idx_evt;

  int nvec = 0, nfail = 0;
  bit done = 0;

  logic [15:0] epos = 0, erev = 0;
  logic edir = 1, em0 = 0, em1 = 0, eill = 0;
  logic ma = 0, mb = 0, mz = 0;

  always #2 clk = ~clk;

  qenc_counter u_dut (
    .clk(clk), .rst_n(rst_n), .ain(ain), .bin(bin), .zin(zin),
    .cfg_updown(cfg_updown), .cfg_a_edge(cfg_a_edge), .cfg_b_edge(cfg_b_edge),
    .cfg_z_edge(cfg_z_edge), .cfg_z_clear(cfg_z_clear), .cfg_cmp1_rev(cfg_cmp1_rev),
    .pos_max(pos_max), .cmp0(cmp0), .cmp1(cmp1), .flag_clr(flag_clr),
    .pos_cnt(pos_cnt), .rev_cnt(rev_cnt), .dir_up(dir_up), .match0(match0),
    .match1(match1), .illegal(illegal), .pos_evt(pos_evt), .idx_evt(idx_evt)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic sel(input logic [1:0] c, input logic p, input logic n);
    return (c[0] & n & ~p) | (c[1] & ~n & p);
  endfunction

  task automatic upd_flags();
    em0 = em0 | (epos == cmp0);
    em1 = em1 | ((cfg_cmp1_rev ? erev : epos) == cmp1);
  endtask

  task automatic apply(input logic na, input logic nb, input logic nz);
    logic up, dn, hz, zc, ev;
    up = 0; dn = 0;
    if (cfg_updown) begin
      up = sel(cfg_a_edge, ma, na) & ~sel(cfg_b_edge, mb, nb);
      dn = sel(cfg_b_edge, mb, nb) & ~sel(cfg_a_edge, ma, na);
    end else begin
      if ((na ^ ma) ^ (nb ^ mb)) begin
        up = na ^ mb;
        dn = ~up;
      end
      if ((na ^ ma) & (nb ^ mb)) eill = 1;
    end
    hz = sel(cfg_z_edge, mz, nz);
    zc = hz & cfg_z_clear;
    ev = up | dn | zc;
    @(negedge clk);
    ain = na; bin = nb; zin = nz;
    repeat (2) @(negedge clk);
    chk("R10 latency hold", pos_cnt, epos);
    if (zc) begin
      epos = 0;
      erev = edir ? erev + 16'd1 : erev - 16'd1;
    end else if (up) begin
      edir = 1;
      if (epos >= pos_max) begin epos = 0; erev = erev + 16'd1; end
      else epos = epos + 16'd1;
    end else if (dn) begin
      edir = 0;
      if (epos == 0) begin epos = pos_max; erev = erev - 16'd1; end
      else epos = epos - 16'd1;
    end
    ma = na; mb = nb; mz = nz;
    @(negedge clk);
    chk("R2/R4/R5/R6 pos", pos_cnt, epos);
    chk("R5/R6 rev", rev_cnt, erev);
    chk("R9 dir", {15'd0, dir_up}, {15'd0, edir});
    chk("R10 pos_evt", {15'd0, pos_evt}, {15'd0, ev});
    chk("R10 idx_evt", {15'd0, idx_evt}, {15'd0, hz});
    upd_flags();
    @(negedge clk);
    chk("R10 pos_evt end", {15'd0, pos_evt}, 16'd0);
    chk("R3 illegal", {15'd0, illegal}, {15'd0, eill});
    chk("R7 match0", {15'd0, match0}, {15'd0, em0});
    chk("R8 match1", {15'd0, match1}, {15'd0, em1});
  endtask

  task automatic clear(input logic [2:0] bits);
    @(negedge clk);
    flag_clr = bits;
    if (bits[0]) em0 = 0;
    if (bits[1]) em1 = 0;
    if (bits[2]) eill = 0;
    upd_flags();
    @(negedge clk);
    flag_clr = 0;
    chk("R7 match0 clr", {15'd0, match0}, {15'd0, em0});
    chk("R8 match1 clr", {15'd0, match1}, {15'd0, em1});
    chk("R3 illegal clr", {15'd0, illegal}, {15'd0, eill});
  endtask

  task automatic set_cmp(input logic [15:0] c0, input logic [15:0] c1, input logic rsel);
    @(negedge clk);
    cmp0 = c0; cmp1 = c1; cfg_cmp1_rev = rsel;
    repeat (2) @(negedge clk);
    upd_flags();
    chk("R7 match0 cmp", {15'd0, match0}, {15'd0, em0});
    chk("R8 match1 cmp", {15'd0, match1}, {15'd0, em1});
  endtask

  logic [1:0] gray [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  initial begin
    int gi;
    repeat (3) @(negedge clk);
    chk("R1 reset pos", pos_cnt, 16'd0);
    chk("R1 reset rev", rev_cnt, 16'd0);
    chk("R1 reset dir", {15'd0, dir_up}, 16'd1);
    chk("R1 reset flags", {11'd0, match0, match1, illegal, pos_evt, idx_evt}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset pos", pos_cnt, 16'd0);
    chk("R1 after reset flags", {13'd0, match0, match1, illegal}, 16'd0);

    // R2 R5 quadrature forward and backward sweeps
    gi = 0;
    for (int i = 0; i < 30; i++) begin
      gi = (gi + 1) % 4;
      apply(gray[gi][1], gray[gi][0], 0);
    end
    chk("R5 forward total rev", rev_cnt, 16'd5);
    for (int i = 0; i < 45; i++) begin
      gi = (gi + 3) % 4;
      apply(gray[gi][1], gray[gi][0], 0);
    end
    // R3 double transition
    apply(~ma, ~mb, 0);
    gi = (gi + 2) % 4;
    clear(3'b100);

    // R4 up/down edge code sweep
    cfg_updown = 1;
    pos_max = 16'd3;
    for (int ca = 0; ca < 4; ca++) begin
      for (int cb = 0; cb < 4; cb++) begin
        cfg_a_edge = ca[1:0];
        cfg_b_edge = cb[1:0];
        apply(~ma, mb, 0);
        apply(~ma, mb, 0);
        apply(ma, ~mb, 0);
        apply(ma, ~mb, 0);
        apply(~ma, ~mb, 0);
        apply(~ma, ~mb, 0);
      end
    end

    // R6 index handling
    cfg_a_edge = 2'b11; cfg_b_edge = 2'b11;
    cfg_z_edge = 2'b01; cfg_z_clear = 1;
    apply(~ma, mb, 0);
    apply(ma, mb, 1);
    apply(ma, mb, 0);
    apply(ma, ~mb, 0);
    apply(~ma, mb, 1);
    apply(ma, mb, 0);
    cfg_z_edge = 2'b11; cfg_z_clear = 0;
    apply(ma, mb, 1);
    apply(ma, mb, 0);

    // R7 R8 compare flags
    set_cmp(16'd2, erev + 16'd1, 1'b1);
    clear(3'b011);
    for (int i = 0; i < 10; i++) apply(~ma, mb, 0);
    clear(3'b011);
    set_cmp(epos, 16'd1, 1'b0);
    clear(3'b001);
    for (int i = 0; i < 6; i++) apply(ma, ~mb, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule